// File: doc/BRIEF.md
# Latched External Status Interrupt

This block watches a handful of external status conditions: a carrier-detect pin, a sync/hunt pin, and a zero-count flag from a baud rate generator. It shows them to the CPU as a set of status bits and drives one shared status interrupt. The two pins are asynchronous. Each one passes through a synchronizer before its edges are detected.

When a pin's interrupt enable is set, its status bit is latched. An edge on that pin while nothing is pending records the new level and raises the interrupt. From then on, the latched bits of all enabled pins stay frozen, so software reads one consistent snapshot. Edges that occur while the latches are closed are not lost. Each enabled pin keeps a parity flag. If a pin toggled an odd number of times, the CPU's reset-status strobe reopens the latches and a fresh interrupt follows at once.

The zero-count source is never latched. Its status bit follows the counter live. It can start an interrupt only while nothing is pending, or at the moment of the strobe if the condition is still present then. A master enable gates only the interrupt output.

Top module: `ext_status_latch`

## Requirements
- R1: After reset the interrupt output is low. A pin whose enable is clear reads its current level. The zero-count status bit reads 0 while zero_cnt_i is low.
- R2: With a pin's enable set and no interrupt pending, an edge on that pin sets the pending interrupt. The pin's status bit then shows the new level. This is visible three clock edges after the pin changes.
- R3: While an interrupt is pending, the status bit of every enabled pin holds its latched value, whatever the pin does.
- R4: A pin whose enable is clear gives a live status bit and never raises the interrupt.
- R5: A pulse on rst_stat_i clears the pending interrupt. If an enabled pin toggled an odd number of times while the interrupt was pending, the interrupt is raised again on the same edge. If the count was even (including zero), it is not.
- R6: With zero_ie_i set, stat_zero_o equals zero_cnt_i and is never held high. When zero_cnt_i is high and nothing is pending, the interrupt is raised. A zero count that occurs while an interrupt is pending raises a new interrupt at the strobe only if zero_cnt_i is still high at that edge.
- R7: On the sync/hunt pin, rising and falling edges each raise the interrupt when its enable is set.
- R8: irq_o is the pending state gated by master_ie_i. Clearing master_ie_i does not change latching or the pending state.
- R9: If a new enabled edge or zero count falls on the same edge as the strobe, the interrupt stays raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_i | input | 1 | Carrier-detect pin, asynchronous |
| sync_i | input | 1 | Sync/hunt pin, asynchronous |
| zero_cnt_i | input | 1 | Baud counter at zero, synchronous to clk |
| carrier_ie_i | input | 1 | Carrier source interrupt enable |
| sync_ie_i | input | 1 | Sync source interrupt enable |
| zero_ie_i | input | 1 | Zero-count source interrupt enable |
| master_ie_i | input | 1 | Master status interrupt enable |
| rst_stat_i | input | 1 | One-cycle reset-status strobe from the CPU |
| stat_carrier_o | output | 1 | Carrier status bit |
| stat_sync_o | output | 1 | Sync/hunt status bit |
| stat_zero_o | output | 1 | Zero-count status bit |
| irq_o | output | 1 | Shared status interrupt request |

## Verification
Two events can land on the same clock edge: the CPU's reset-status strobe, and a fresh cause (a synchronized pin edge or a zero count). The design must then re-raise the interrupt instead of letting the clear win.

The bench provokes this by counting the synchronizer delay. A carrier change is driven on a falling edge, and the strobe is placed on exactly the edge where the synchronized edge appears. A second case holds zero_cnt_i high across the strobe. Both cases are judged by irq_o on the next half cycle, which must be high, while a strobe with no cause leaves it low.

// File: rtl/ext_status_pkg.sv
package ext_status_pkg;
  localparam int PIN_SRCS    = 2;
  localparam int IDX_CARRIER = 0;
  localparam int IDX_SYNC    = 1;
  localparam int SYNC_DEPTH  = 2;
endpackage

// File: rtl/est_sync.sv
module est_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/est_chan.sv
module est_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic arm,
  input  logic ie,
  input  logic pend,
  input  logic rst_stat,
  output logic hit,
  output logic tog,
  output logic stat
);
  logic prev_q, lat_q, tog_q;
  logic edge_w;

  // prev_q always follows the synchronized level
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign edge_w = arm & (lvl ^ prev_q);
  assign hit    = edge_w & ie;

  // latch is transparent while idle or at the strobe, frozen while pending
  always_ff @(posedge clk) begin
    if (!rst_n)                lat_q <= 1'b0;
    else if (rst_stat || !pend) lat_q <= lvl;
  end

  // parity of enabled edges seen while pending
  always_ff @(posedge clk) begin
    if (!rst_n)          tog_q <= 1'b0;
    else if (rst_stat)   tog_q <= 1'b0;
    else if (pend && hit) tog_q <= ~tog_q;
  end

  assign tog  = tog_q;
  assign stat = ie ? lat_q : lvl;
endmodule

// File: rtl/ext_status_latch.sv
module ext_status_latch
  import ext_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_i,
  input  logic sync_i,
  input  logic zero_cnt_i,
  input  logic carrier_ie_i,
  input  logic sync_ie_i,
  input  logic zero_ie_i,
  input  logic master_ie_i,
  input  logic rst_stat_i,
  output logic stat_carrier_o,
  output logic stat_sync_o,
  output logic stat_zero_o,
  output logic irq_o
);
  localparam int WARM   = SYNC_DEPTH + 1;
  localparam int WARM_W = $clog2(WARM + 1);

  logic [PIN_SRCS-1:0] pin_raw, pin_lvl, ie_vec, hit_vec, tog_vec, stat_vec;
  logic [WARM_W-1:0]   warm_q;
  logic                arm, pend_q, zero_hit, trig;

  assign pin_raw[IDX_CARRIER] = carrier_i;
  assign pin_raw[IDX_SYNC]    = sync_i;
  assign ie_vec[IDX_CARRIER]  = carrier_ie_i;
  assign ie_vec[IDX_SYNC]     = sync_ie_i;

  est_sync #(.W(PIN_SRCS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_lvl)
  );

  // suppress edges until the synchronizer holds real pin data
  always_ff @(posedge clk) begin
    if (!rst_n)            warm_q <= '0;
    else if (warm_q != WARM[WARM_W-1:0]) warm_q <= warm_q + 1'b1;
  end
  assign arm = (warm_q == WARM[WARM_W-1:0]);

  for (genvar g = 0; g < PIN_SRCS; g++) begin : g_chan
    est_chan u_chan (
      .clk(clk), .rst_n(rst_n), .lvl(pin_lvl[g]), .arm(arm),
      .ie(ie_vec[g]), .pend(pend_q), .rst_stat(rst_stat_i),
      .hit(hit_vec[g]), .tog(tog_vec[g]), .stat(stat_vec[g])
    );
  end

  assign zero_hit = zero_ie_i & zero_cnt_i;
  assign trig     = (|hit_vec) | zero_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (rst_stat_i) pend_q <= (|tog_vec) | trig;
    else if (!pend_q)    pend_q <= trig;
  end

  assign stat_carrier_o = stat_vec[IDX_CARRIER];
  assign stat_sync_o    = stat_vec[IDX_SYNC];
  assign stat_zero_o    = zero_hit;
  assign irq_o          = pend_q & master_ie_i;
endmodule

// File: rtl/est_checker.sv
module est_checker
  import ext_status_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                rst_stat_i,
  input logic                zero_cnt_i,
  input logic                zero_ie_i,
  input logic                master_ie_i,
  input logic                carrier_ie_i,
  input logic                stat_carrier_o,
  input logic                stat_zero_o,
  input logic                irq_o,
  input logic                pend,
  input logic [PIN_SRCS-1:0] hit_vec,
  input logic [PIN_SRCS-1:0] tog_vec
);
  a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_ie_i |-> !irq_o);

  a_r6_zero_not_held: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_cnt_i |-> !stat_zero_o);

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rst_stat_i && carrier_ie_i) |=> (!carrier_ie_i || $stable(stat_carrier_o)));

  a_r2_edge_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && (|hit_vec)) |=> pend);

  a_r5_odd_reraise: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_stat_i && (|tog_vec)) |=> pend);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_stat_i && !(|tog_vec) && !(|hit_vec) && !(zero_ie_i && zero_cnt_i)) |=> !pend);

  a_r3_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rst_stat_i) |=> pend);
endmodule

bind ext_status_latch est_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rst_stat_i(rst_stat_i), .zero_cnt_i(zero_cnt_i),
  .zero_ie_i(zero_ie_i), .master_ie_i(master_ie_i), .carrier_ie_i(carrier_ie_i),
  .stat_carrier_o(stat_carrier_o), .stat_zero_o(stat_zero_o), .irq_o(irq_o),
  .pend(pend_q), .hit_vec(hit_vec), .tog_vec(tog_vec)
);

// File: tb/ext_status_latch_tb_top.sv
`timescale 1ns/1ps
module ext_status_latch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier = 0, syncp = 0, zero = 0;
  logic car_ie = 0, syn_ie = 0, zer_ie = 0, mie = 0, rst_stat = 0;
  logic st_car, st_syn, st_zero, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_status_latch dut_i (
    .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .sync_i(syncp),
    .zero_cnt_i(zero), .carrier_ie_i(car_ie), .sync_ie_i(syn_ie),
    .zero_ie_i(zer_ie), .master_ie_i(mie), .rst_stat_i(rst_stat),
    .stat_carrier_o(st_car), .stat_sync_o(st_syn), .stat_zero_o(st_zero),
    .irq_o(irq)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    rst_stat = 1; tick(1); rst_stat = 0; tick(1);
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 carrier live", st_car, 0);
    chk("R1 zero", st_zero, 0);
  endtask

  task automatic t_disabled();
    mie = 1; carrier = 1; tick(4);
    chk("R4 live level", st_car, 1);
    chk("R4 no irq", irq, 0);
    carrier = 0; tick(4);
    chk("R4 live low", st_car, 0);
  endtask

  task automatic t_latch_odd();
    car_ie = 1; tick(2);
    carrier = 1; tick(3);
    chk("R2 irq raised", irq, 1);
    chk("R2 latched level", st_car, 1);
    carrier = 0; tick(4);
    chk("R3 frozen", st_car, 1);
    strobe();
    chk("R5 odd reraise", irq, 1);
    chk("R5 new snapshot", st_car, 0);
    strobe();
    chk("R5 cleared", irq, 0);
  endtask

  task automatic t_even();
    carrier = 1; tick(4);
    chk("R2 raised again", irq, 1);
    carrier = 0; tick(4);
    carrier = 1; tick(4);
    chk("R3 frozen even", st_car, 1);
    strobe();
    chk("R5 even no irq", irq, 0);
    carrier = 0; tick(4); strobe(); tick(1);
    chk("R5 cleanup", irq, 0);
  endtask

  task automatic t_sync_edges();
    syn_ie = 1; tick(1);
    syncp = 1; tick(4);
    chk("R7 rise irq", irq, 1);
    strobe();
    chk("R7 cleared", irq, 0);
    syncp = 0; tick(4);
    chk("R7 fall irq", irq, 1);
    chk("R7 status", st_syn, 0);
    strobe();
    syn_ie = 0; tick(1);
  endtask

  task automatic t_zero();
    zer_ie = 1;
    zero = 1; tick(1);
    chk("R6 zero live", st_zero, 1);
    chk("R6 zero irq", irq, 1);
    zero = 0; tick(1);
    chk("R6 not held", st_zero, 0);
    strobe();
    chk("R6 gone no irq", irq, 0);
    carrier = 1; tick(4);
    zero = 1; tick(1); zero = 0; tick(1);
    strobe();
    chk("R6 missed zero", irq, 0);
    carrier = 0; tick(4);
    zero = 1; tick(1);
    strobe();
    chk("R9 zero at strobe", irq, 1);
    zero = 0; tick(1);
    strobe();
    chk("R6 cleared", irq, 0);
    zer_ie = 0;
  endtask

  task automatic t_master();
    mie = 0; carrier = 1; tick(4);
    chk("R8 gated", irq, 0);
    carrier = 0; tick(4);
    chk("R8 still latched", st_car, 1);
    mie = 1; tick(1);
    chk("R8 pending kept", irq, 1);
    strobe();
    chk("R8 reraise after strobe", irq, 1);
    strobe();
  endtask

  task automatic t_collide();
    carrier = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst_stat = 1;
    @(negedge clk); rst_stat = 0;
    chk("R9 edge with strobe", irq, 1);
    strobe();
    chk("R9 clear after", irq, 0);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(10);
    t_reset();
    t_disabled();
    t_latch_odd();
    t_even();
    t_sync_edges();
    t_zero();
    t_master();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule